// File: doc/BRIEF.md
# Maskable Real-Time-Clock Alarm Comparator

This block holds four alarm bytes (seconds, minutes, hours, date) and compares them against the current BCD time. The time comes from a separate timekeeping counter, which also supplies a one-cycle second strobe. Bit 7 of each alarm byte is a mask flag: a masked field is left out of the comparison. The mask patterns choose how often the alarm repeats: monthly, daily, hourly, once a minute or once a second. When the comparison succeeds on a strobe, the block emits a one-clock interrupt pulse.

Software reaches the alarm bytes through a byte-wide register port with a shared offset. Offset 0 is seconds, 1 is minutes, 2 is hours and 3 is date. A write whose BCD value is out of range for its field is dropped, and the old byte stays in place. A read returns the stored byte, mask bit included.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all four alarm bytes read back as 0x00 and `alarm_irq` is low.
- R2: `reg_rdata` combinationally returns the whole stored byte, bit 7 included, at offset `reg_addr` (0 seconds, 1 minutes, 2 hours, 3 date).
- R3: A seconds or minutes write takes bits 6:4 as tens and bits 3:0 as units. It stores the full byte only when tens*10+units is at most 59; otherwise the old byte is kept.
- R4: An hours write takes bits 5:4 as tens and bits 3:0 as units. It stores the full byte only when the value is at most 23.
- R5: A date write decodes bits 5:0 the same way as hours. It stores the full byte only when the value is nonzero.
- R6: `alarm_irq` is high for exactly the one clock after a cycle in which `tick` is high and the comparison succeeds. It never rises after a cycle with `tick` low.
- R7: With no mask bit set, the alarm fires only when all four fields match. Seconds and minutes compare on bits 6:0; hours and date compare on bits 5:0.
- R8: With only the date mask set, the date field is ignored and hours, minutes and seconds must match (daily).
- R9: With the date and hours masks set and the others clear, only minutes and seconds must match (hourly).
- R10: With the date, hours and minutes masks set and seconds clear, only seconds must match (once a minute).
- R11: Any other mask combination, including all four masks set, fires on every `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Alarm byte offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick | input | 1 | One-cycle second strobe |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
The comparison is driven with time values that match every field. It is also driven with values that differ in exactly one field, once for each of the four nested mask patterns, which shows which fields each repeat rate includes and which it drops. Non-nested mask patterns, such as a mask on hours alone, are tried and must fire on every strobe. A matching time held with no strobe must stay silent. Writes at each field's limit, one step past it, with a nonzero units digit above 9, and with bit 7 set show that validation reads only the low bits and stores the whole byte.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

   localparam int NUM_FIELDS = 4;
   localparam int IDX_SEC    = 0;
   localparam int IDX_MIN    = 1;
   localparam int IDX_HOUR   = 2;
   localparam int IDX_DATE   = 3;
   localparam int MASK_BIT   = 7;

   typedef enum logic [2:0] {
      RATE_MONTH,
      RATE_DAY,
      RATE_HOUR,
      RATE_MINUTE,
      RATE_SECOND
   } rate_e;

   // Turn a seven-bit BCD pair into its binary value (no digit range check).
   function automatic logic [7:0] bcd_value(input logic [6:0] v);
      return 8'(v[6:4]) * 8'd10 + 8'(v[3:0]);
   endfunction

   // Decide whether a written byte is accepted for the given field.
   function automatic logic field_accepts(input int idx, input logic [7:0] d);
      logic [7:0] val;
      logic       ok;
      ok = 1'b0;
      case (idx)
         IDX_SEC, IDX_MIN: begin
            val = bcd_value(d[6:0]);
            ok  = (val <= 8'd59);
         end
         IDX_HOUR: begin
            val = bcd_value({1'b0, d[5:0]});
            ok  = (val <= 8'd23);
         end
         default: begin
            val = bcd_value({1'b0, d[5:0]});
            ok  = (val != 8'd0);
         end
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/alarm_reg_bank.sv
module alarm_reg_bank #(
   parameter int NUM    = 4,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [NUM-1:0][DATA_W-1:0] bytes_q
);

   for (genvar i = 0; i < NUM; i++) begin : g_field
      logic              hit;
      logic              ok;
      logic [DATA_W-1:0] q;

      assign hit = wr_en && (wr_addr == ADDR_W'(i));
      assign ok  = alarm_pkg::field_accepts(i, wr_data[7:0]);

      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (hit && ok)
            q <= wr_data;
      end

      assign bytes_q[i] = q;
   end

endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode (
   input  logic [3:0] masks,
   output logic [3:0] field_en
);
   import alarm_pkg::*;

   rate_e rate;

   always_comb begin
      unique case ({masks[IDX_DATE], masks[IDX_HOUR], masks[IDX_MIN], masks[IDX_SEC]})
         4'b0000: rate = RATE_MONTH;
         4'b1000: rate = RATE_DAY;
         4'b1100: rate = RATE_HOUR;
         4'b1110: rate = RATE_MINUTE;
         default: rate = RATE_SECOND;
      endcase
   end

   always_comb begin
      field_en = 4'b0000;
      case (rate)
         RATE_MONTH:  field_en = 4'b1111;
         RATE_DAY:    field_en = 4'b0111;
         RATE_HOUR:   field_en = 4'b0011;
         RATE_MINUTE: field_en = 4'b0001;
         default:     field_en = 4'b0000;
      endcase
   end

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [3:0] field_en,
   input  logic [6:0] al_sec,
   input  logic [6:0] al_min,
   input  logic [5:0] al_hour,
   input  logic [5:0] al_date,
   input  logic [6:0] now_sec,
   input  logic [6:0] now_min,
   input  logic [5:0] now_hour,
   input  logic [5:0] now_date,
   output logic       irq
);
   import alarm_pkg::*;

   logic [3:0] eq;

   assign eq[IDX_SEC]  = !field_en[IDX_SEC]  || (al_sec  == now_sec);
   assign eq[IDX_MIN]  = !field_en[IDX_MIN]  || (al_min  == now_min);
   assign eq[IDX_HOUR] = !field_en[IDX_HOUR] || (al_hour == now_hour);
   assign eq[IDX_DATE] = !field_en[IDX_DATE] || (al_date == now_date);

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq <= 1'b0;
      else
         irq <= tick && (&eq);
   end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick,
   input  logic [6:0]        now_sec,
   input  logic [6:0]        now_min,
   input  logic [5:0]        now_hour,
   input  logic [5:0]        now_date,
   output logic              alarm_irq
);
   import alarm_pkg::*;

   localparam int NUM = NUM_FIELDS;

   if (DATA_W != 8) begin : g_bad_width
      $error("rtc_alarm_match: DATA_W must be 8");
   end
   if ((1 << ADDR_W) < NUM) begin : g_bad_addr
      $error("rtc_alarm_match: ADDR_W too narrow for the alarm bytes");
   end

   logic [NUM-1:0][DATA_W-1:0] alarm_bytes;
   logic [3:0]                 masks;
   logic [3:0]                 field_en;

   alarm_reg_bank #(.NUM(NUM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .bytes_q (alarm_bytes)
   );

   for (genvar i = 0; i < NUM; i++) begin : g_mask
      assign masks[i] = alarm_bytes[i][MASK_BIT];
   end

   alarm_rate_decode u_rate (
      .masks    (masks),
      .field_en (field_en)
   );

   alarm_compare u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .field_en (field_en),
      .al_sec   (alarm_bytes[IDX_SEC][6:0]),
      .al_min   (alarm_bytes[IDX_MIN][6:0]),
      .al_hour  (alarm_bytes[IDX_HOUR][5:0]),
      .al_date  (alarm_bytes[IDX_DATE][5:0]),
      .now_sec  (now_sec),
      .now_min  (now_min),
      .now_hour (now_hour),
      .now_date (now_date),
      .irq      (alarm_irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int k = 0; k < NUM; k++)
         if (reg_addr == ADDR_W'(k))
            reg_rdata = alarm_bytes[k];
   end

endmodule

// File: rtl/rtc_alarm_match_checker.sv
module rtc_alarm_match_checker (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      reg_addr,
   input logic            reg_wr,
   input logic [7:0]      reg_wdata,
   input logic            tick,
   input logic            alarm_irq,
   input logic [3:0][7:0] alarm_bytes
);

   function automatic int tens_units(input logic [6:0] v);
      return int'(v[6:4]) * 10 + int'(v[3:0]);
   endfunction

   // R6: a pulse always follows a strobe
   p_irq_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> $past(tick));

   // R6: no strobe, no pulse on the next clock
   p_quiet_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !alarm_irq);

   // R3: out-of-range seconds write leaves the byte alone
   p_sec_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && tens_units(reg_wdata[6:0]) > 59)
      |=> $stable(alarm_bytes[0]));

   // R3: in-range minutes write is stored whole
   p_min_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1 && tens_units(reg_wdata[6:0]) <= 59)
      |=> alarm_bytes[1] == $past(reg_wdata));

   // R4: out-of-range hours write is dropped
   p_hour_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2 && tens_units({1'b0, reg_wdata[5:0]}) > 23)
      |=> $stable(alarm_bytes[2]));

   // R5: zero date write is dropped
   p_date_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3 && tens_units({1'b0, reg_wdata[5:0]}) == 0)
      |=> $stable(alarm_bytes[3]));

   // R11: all four masks set fires on every strobe
   p_all_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && alarm_bytes[0][7] && alarm_bytes[1][7] &&
       alarm_bytes[2][7] && alarm_bytes[3][7]) |=> alarm_irq);

endmodule

bind rtc_alarm_match rtc_alarm_match_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_wdata   (reg_wdata),
   .tick        (tick),
   .alarm_irq   (alarm_irq),
   .alarm_bytes (alarm_bytes)
);

// File: tb/rtc_alarm_match_bench.sv
`timescale 1ns/1ps
module rtc_alarm_match_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tick = 1'b0;
   logic [6:0] now_sec = '0;
   logic [6:0] now_min = '0;
   logic [5:0] now_hour = '0;
   logic [5:0] now_date = '0;
   logic       alarm_irq;

   int    n_checks = 0;
   int    n_fail = 0;
   string phase = "R1";
   bit    done = 1'b0;

   always #2 clk = ~clk;

   rtc_alarm_match u_rtc_alarm_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tick      (tick),
      .now_sec   (now_sec),
      .now_min   (now_min),
      .now_hour  (now_hour),
      .now_date  (now_date),
      .alarm_irq (alarm_irq)
   );

   // ---------------- reference model ----------------
   byte unsigned m_bytes[4];
   bit           m_irq = 1'b0;

   function automatic int dec(input int v);
      return ((v >> 4) & 7) * 10 + (v & 15);
   endfunction

   function automatic bit model_accepts(input int idx, input int d);
      if (idx <= 1) return dec(d & 8'h7f) <= 59;
      if (idx == 2) return dec(d & 8'h3f) <= 23;
      return dec(d & 8'h3f) != 0;
   endfunction

   function automatic bit model_fire(input int s, input int mi, input int h, input int d);
      bit ms, mm, mh, md;
      bit same_s, same_m, same_h, same_d;
      ms = m_bytes[0][7]; mm = m_bytes[1][7]; mh = m_bytes[2][7]; md = m_bytes[3][7];
      same_s = (m_bytes[0] & 8'h7f) == s;
      same_m = (m_bytes[1] & 8'h7f) == mi;
      same_h = (m_bytes[2] & 8'h3f) == h;
      same_d = (m_bytes[3] & 8'h3f) == d;
      if (!md && !mh && !mm && !ms) return same_d && same_h && same_m && same_s;
      if (md && !mh && !mm && !ms)  return same_h && same_m && same_s;
      if (md && mh && !mm && !ms)   return same_m && same_s;
      if (md && mh && mm && !ms)    return same_s;
      return 1'b1;
   endfunction

   task automatic check(input string req, input int got, input int exp, input string what);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   always @(posedge clk) begin
      bit nxt;
      if (!rst_n) begin
         foreach (m_bytes[k]) m_bytes[k] = 8'h00;
         m_irq = 1'b0;
      end else begin
         nxt = tick && model_fire(now_sec, now_min, now_hour, now_date);
         if (reg_wr && model_accepts(reg_addr, reg_wdata))
            m_bytes[reg_addr] = reg_wdata;
         m_irq = nxt;
      end
      #1;
      if (!done && rst_n) begin
         check(phase, alarm_irq, m_irq, "per-clock irq");
         check(phase, reg_rdata, m_bytes[reg_addr], "per-clock read data");
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic expect_reg(input string req, input int a, input int exp);
      @(negedge clk);
      reg_addr = 2'(a);
      #0.5;
      check(req, reg_rdata, exp, "readback");
   endtask

   task automatic strobe(input string req, input int s, input int mi, input int h,
                         input int d, input bit exp);
      @(negedge clk);
      now_sec = 7'(s); now_min = 7'(mi); now_hour = 6'(h); now_date = 6'(d);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      check(req, alarm_irq, exp, "irq after strobe");
      @(negedge clk);
      check(req, alarm_irq, 0, "irq one clock later");
   endtask

   task automatic set_alarm(input int s, input int mi, input int h, input int d);
      wr(0, s); wr(1, mi); wr(2, h); wr(3, d);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      phase = "R1";
      @(negedge clk);
      check("R1", alarm_irq, 0, "irq after reset");
      for (int k = 0; k < 4; k++) expect_reg("R1", k, 8'h00);

      phase = "R3";
      wr(0, 8'h59); expect_reg("R3", 0, 8'h59);
      wr(0, 8'h60); expect_reg("R3", 0, 8'h59);
      wr(0, 8'h85); expect_reg("R3", 0, 8'h85);
      wr(1, 8'h5a); expect_reg("R3", 1, 8'h00);
      wr(1, 8'h0a); expect_reg("R3", 1, 8'h0a);

      phase = "R4";
      wr(2, 8'h23); expect_reg("R4", 2, 8'h23);
      wr(2, 8'h24); expect_reg("R4", 2, 8'h23);
      wr(2, 8'ha3); expect_reg("R4", 2, 8'ha3);

      phase = "R5";
      wr(3, 8'h00); expect_reg("R5", 3, 8'h00);
      wr(3, 8'h80); expect_reg("R5", 3, 8'h00);
      wr(3, 8'h31); expect_reg("R5", 3, 8'h31);

      phase = "R2";
      wr(1, 8'hc5); expect_reg("R2", 1, 8'hc5);

      phase = "R7";
      set_alarm(8'h30, 8'h15, 8'h12, 8'h07);
      strobe("R7", 8'h30, 8'h15, 8'h12, 8'h07, 1);
      strobe("R7", 8'h30, 8'h15, 8'h12, 8'h08, 0);
      strobe("R7", 8'h31, 8'h15, 8'h12, 8'h07, 0);
      strobe("R7", 8'h30, 8'h16, 8'h12, 8'h07, 0);

      phase = "R6";
      @(negedge clk);
      now_sec = 7'h30; now_min = 7'h15; now_hour = 6'h12; now_date = 6'h07;
      repeat (3) @(negedge clk);
      check("R6", alarm_irq, 0, "matching time without strobe");

      phase = "R8";
      wr(3, 8'h87);
      strobe("R8", 8'h30, 8'h15, 8'h12, 8'h20, 1);
      strobe("R8", 8'h30, 8'h15, 8'h13, 8'h20, 0);

      phase = "R9";
      wr(2, 8'h92);
      strobe("R9", 8'h30, 8'h15, 8'h05, 8'h01, 1);
      strobe("R9", 8'h30, 8'h44, 8'h05, 8'h01, 0);

      phase = "R10";
      wr(1, 8'h95);
      strobe("R10", 8'h30, 8'h44, 8'h05, 8'h01, 1);
      strobe("R10", 8'h29, 8'h44, 8'h05, 8'h01, 0);

      phase = "R11";
      wr(0, 8'hb0);
      strobe("R11", 8'h01, 8'h02, 8'h03, 8'h04, 1);
      set_alarm(8'h10, 8'h20, 8'h85, 8'h05);
      strobe("R11", 8'h59, 8'h59, 8'h23, 8'h31, 1);
      set_alarm(8'h10, 8'h20, 8'h05, 8'h05);
      wr(1, 8'ha0);
      strobe("R11", 8'h00, 8'h00, 8'h00, 8'h01, 1);

      phase = "R6";
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      check("R6", alarm_irq, 1, "first of back-to-back strobes");
      tick = 1'b0;
      @(negedge clk);
      check("R6", alarm_irq, 0, "pulse ends after strobe drops");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule